// File: doc/BRIEF.md
# Partitioned 8x8 Unsigned Multiplier

This block multiplies two unsigned 8-bit operands and returns their exact 16-bit product. Each operand is cut into a low nibble and a high nibble. Four 4x4 sub-multipliers form the four nibble products.

Each sub-multiplier works column by column. For every output column it sums the AND of each bit pair whose indices add up to that column, and it passes the column carry on to the next column.

The low-by-low product sits at the bottom of the result and the high-by-high product sits eight places above it. The two cross products are first added to each other, then shifted up by four places. Parallel-prefix adders of the Kogge-Stone kind do every addition.

The product can leave through an optional output register. With the default setting that register is present, and it loads when the enable input is high.

Top module: `part_mul8`

## Requirements
- R1: While `rst_n` is low, `prod` reads 0, whatever the operands and the enable.
- R2: With the output register present (default), a rising clock edge with `en` high loads the product of `op_a` and `op_b`, and `prod` shows it from that edge on, one cycle of latency.
- R3: A rising edge with `en` low leaves `prod` unchanged, even when the operands change.
- R4: The product is exact for all 65536 operand pairs: `prod` equals `op_a` times `op_b`, both read as unsigned.
- R5: Bits 3..0 of the product equal bits 3..0 of the product of the two low nibbles (`op_a[3:0]` times `op_b[3:0]`).
- R6: When either operand is 0, the product is 0.
- R7: The largest product, 255 x 255 = 65025 (0xFE01), fits in 16 bits, and the final 16-bit prefix adder never produces a carry out.
- R8: Swapping the two operands gives the same product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset; it clears the output register |
| en | input | 1 | Load enable for the output register |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| prod | output | 16 | Unsigned product |

## Verification
The assertions take for granted that `op_a`, `op_b` and `en` are steady around each rising edge. They also assume that reset is released away from an edge, so the value sampled one cycle back is the one that was loaded.

The stimulus changes inputs only on falling edges, and it releases reset on a falling edge. This keeps every sampled operand pair defined.

The exhaustive sweep holds `en` high on every cycle, so the one-cycle relation is checked on every edge. Separate short windows with `en` low change the operands while the output must hold.

// File: rtl/part_mul_pkg.sv
package part_mul_pkg;
  parameter int unsigned DEF_HALF = 4;

  function automatic int unsigned prefix_levels(input int unsigned w);
    return $clog2(w);
  endfunction
endpackage

// File: rtl/xw_mul.sv
module xw_mul #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int unsigned COLS = 2 * N;
  localparam int unsigned AW   = $clog2(2 * N) + 1;

  always_comb begin
    logic [AW-1:0] carry;
    logic [AW-1:0] acc;
    carry = '0;
    p     = '0;
    for (int c = 0; c < COLS - 1; c++) begin
      acc = carry;
      for (int i = 0; i < N; i++) begin
        if ((c - i) >= 0 && (c - i) < N) begin
          acc = acc + AW'(a[i] & b[c-i]);
        end
      end
      p[c]  = acc[0];
      carry = acc >> 1;
    end
    p[COLS-1] = carry[0];
  end
endmodule

// File: rtl/ks_adder.sv
module ks_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s,
  output logic         cout
);
  import part_mul_pkg::*;
  localparam int unsigned LEVELS = prefix_levels(W);

  logic [W-1:0] gen0, prp0, gfin;

  assign gen0 = x & y;
  assign prp0 = x ^ y;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int unsigned STRIDE = 1 << lv;
    logic [W-1:0] gi, pi_, go, po;
    if (lv == 0) begin : g_first
      assign gi  = gen0;
      assign pi_ = prp0;
    end else begin : g_next
      assign gi  = g_lvl[lv-1].go;
      assign pi_ = g_lvl[lv-1].po;
    end
    always_comb begin
      for (int i = 0; i < W; i++) begin
        if (i >= STRIDE) begin
          go[i] = gi[i] | (pi_[i] & gi[i-STRIDE]);
          po[i] = pi_[i] & pi_[i-STRIDE];
        end else begin
          go[i] = gi[i];
          po[i] = pi_[i];
        end
      end
    end
  end

  assign gfin = g_lvl[LEVELS-1].go;
  assign s    = prp0 ^ {gfin[W-2:0], 1'b0};
  assign cout = gfin[W-1];
endmodule

// File: rtl/part_mul8.sv
module part_mul8 #(
  parameter int unsigned HALF    = part_mul_pkg::DEF_HALF,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [2*HALF-1:0]   op_a,
  input  logic [2*HALF-1:0]   op_b,
  output logic [4*HALF-1:0]   prod
);
  localparam int unsigned OPW = 2 * HALF;
  localparam int unsigned PW  = 2 * OPW;
  localparam int unsigned PAD = PW - OPW - 1 - HALF;

  logic [HALF-1:0] a_half [2];
  logic [HALF-1:0] b_half [2];
  logic [OPW-1:0]  pp     [4];
  logic [OPW-1:0]  cross_s;
  logic            cross_c;
  logic [PW-1:0]   addend_x, addend_y, prod_comb;
  logic            fin_cout;

  assign a_half[0] = op_a[HALF-1:0];
  assign a_half[1] = op_a[OPW-1:HALF];
  assign b_half[0] = op_b[HALF-1:0];
  assign b_half[1] = op_b[OPW-1:HALF];

  // pp[0]=lo*lo, pp[1]=lo_a*hi_b, pp[2]=hi_a*lo_b, pp[3]=hi*hi
  for (genvar k = 0; k < 4; k++) begin : g_sub
    xw_mul #(.N(HALF)) u_xw (
      .a (a_half[k/2]),
      .b (b_half[k%2]),
      .p (pp[k])
    );
  end

  ks_adder #(.W(OPW)) u_cross (
    .x    (pp[1]),
    .y    (pp[2]),
    .s    (cross_s),
    .cout (cross_c)
  );

  assign addend_x = {pp[3], pp[0]};
  assign addend_y = {{PAD{1'b0}}, cross_c, cross_s, {HALF{1'b0}}};

  ks_adder #(.W(PW)) u_final (
    .x    (addend_x),
    .y    (addend_y),
    .s    (prod_comb),
    .cout (fin_cout)
  );

  if (OUT_REG) begin : g_reg
    logic [PW-1:0] prod_q, prod_nxt;

    always_comb begin
      prod_nxt = prod_q;
      if (en) prod_nxt = prod_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= '0;
      else        prod_q <= prod_nxt;
    end

    assign prod = prod_q;
  end else begin : g_comb
    assign prod = prod_comb;
  end
endmodule

// File: rtl/part_mul8_chk.sv
module part_mul8_chk #(
  parameter int unsigned HALF = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [2*HALF-1:0] op_a,
  input logic [2*HALF-1:0] op_b,
  input logic [4*HALF-1:0] prod,
  input logic              fin_cout
);
  localparam int unsigned PW = 4 * HALF;

  always_comb begin
    if (!rst_n) AST_RESET_ZERO: assert (prod == '0); // R1
  end

  AST_LOAD_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> prod == PW'($past(op_a)) * PW'($past(op_b))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(prod)); // R3

  AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> prod[HALF-1:0] == HALF'($past(op_a[HALF-1:0]) * $past(op_b[HALF-1:0]))); // R5

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_a == '0 || op_b == '0)) |=> prod == '0); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_cout); // R7
endmodule

bind part_mul8 part_mul8_chk #(.HALF(HALF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .op_a     (op_a),
  .op_b     (op_b),
  .prod     (prod),
  .fin_cout (fin_cout)
);

// File: tb/sim_part_mul8.sv
module sim_part_mul8;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [7:0]  op_a, op_b;
  logic [15:0] prod;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] last_push = '0;

  part_mul8 u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .op_a  (op_a),
    .op_b  (op_b),
    .prod  (prod)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: prod actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk);
    op_a = a;
    op_b = b;
    en   = 1'b1;
    last_push = 16'(a) * 16'(b);
    exp_q.push_back(last_push);
    tag_q.push_back(tag);
  endtask

  // R3: operands move while en is low; prod must keep the last loaded value
  task automatic hold_check(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      en   = 1'b0;
      op_a = 8'(37 * k + 11);
      op_b = 8'(91 * k + 5);
      @(posedge clk);
      #1;
      check("R3", prod, last_push);
    end
  endtask

  // monitor: one result per edge that had en high, visible one cycle later (R2)
  initial begin
    forever begin
      logic fire;
      @(posedge clk);
      fire = en && rst_n;
      #1;
      if (fire) begin
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected load, actual=%0d expected=none", prod);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, prod, e);
        end
      end
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en    = 1'b1;
    op_a  = 8'd200;
    op_b  = 8'd199;
    #23;
    check("R1", prod, 16'd0);
    @(posedge clk);
    #1;
    check("R1", prod, 16'd0);
    @(negedge clk);
    en    = 1'b0;
    rst_n = 1'b1;

    push(8'd255, 8'd255, "R7");
    push(8'd0,   8'd200, "R6");
    push(8'd200, 8'd0,   "R6");
    push(8'h3C,  8'hA5,  "R8");
    push(8'hA5,  8'h3C,  "R8");
    push(8'h0F,  8'h0F,  "R5");
    push(8'hF7,  8'h1B,  "R5");
    push(8'h80,  8'h80,  "R2");
    hold_check(4);

    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        push(8'(i), 8'(j), "R4");
      end
    end
    @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    #2;
    hold_check(2);
    if (exp_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL R2: queue left=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule